// File: doc/BRIEF.md
# Delayed-Sweep Mode Controller

This block sits between a digital delay generator and a second sweep timebase. It watches the end-of-delay pulse, the delay-interval level and the trigger that feeds the second timebase. From these it decides when that timebase may begin a sweep. Software or a front-panel decoder picks one of three behaviours. In independent mode the delay never launches a sweep. In start-after-delay mode the sweep is launched the moment the delay runs out. In triggerable-after-delay mode the delay only enables the timebase, and the sweep is launched by the first trigger that follows.

Once a sweep has been launched, the controller holds off until the timebase reports that the sweep has finished, then rearms for the next delay interval. A mode change between the two delaying modes while the controller is armed leaves it locked out. In that state there is no output and the armed flag is low. Only a pass through independent mode releases it.

Top module: `dsm_sweep_ctrl`

## Requirements
- R1: After reset, `sweep_start` and `armed` are both 0.
- R2: Mode codes 2'b00 and 2'b11 are independent mode. While one of them is sampled, `sweep_start` stays 0 and `armed` is 0 from the next cycle on, whatever the other inputs do.
- R3: In start-after-delay mode (code 2'b01), with the controller armed and the mode unchanged, a `dly_trig` pulse sampled at clock edge N makes `sweep_start` high in the cycle after edge N.
- R4: In triggerable-after-delay mode (code 2'b10), a sampled `dly_trig` moves the armed controller to waiting, and `armed` stays 1. The first `sweep_trig` sampled later while `dly_interval` is low raises `sweep_start` in the cycle after that edge.
- R5: In triggerable-after-delay mode, a `sweep_trig` is ignored if it arrives before the end-of-delay pulse (including in the same cycle as it), or while `dly_interval` is high.
- R6: `sweep_start` is never high for two cycles in a row.
- R7: In the cycle `sweep_start` is high, `armed` is 0. No further sweep is launched until `sweep_done` is sampled, and `armed` returns to 1 in the cycle after that edge.
- R8: A change of the mode code from one delaying mode to the other, sampled while armed or waiting, enters lockout. In lockout `armed` and `sweep_start` stay 0.
- R9: Lockout persists under any delaying mode code. It clears only when independent mode is sampled, after which a delaying mode arms the controller again.
- R10: From idle, holding a delaying mode code for one clock edge raises `armed` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Mode code: 00/11 independent, 01 start-after-delay, 10 triggerable-after-delay |
| dly_trig | input | 1 | One-cycle pulse marking the end of a delay interval |
| dly_interval | input | 1 | High while a delay interval is running |
| sweep_trig | input | 1 | Trigger pulse for the second timebase |
| sweep_done | input | 1 | Timebase reports that the sweep has ended |
| sweep_start | output | 1 | One-cycle command to begin a sweep |
| armed | output | 1 | Controller is armed or waiting for a trigger |

## Verification
Directed sequences walk each mode through its launch path. Start-after-delay with a lone `dly_trig` shows an immediate launch. Triggerable-after-delay is tried with triggers before the end pulse, during a high `dly_interval` and after the end, which separates accepted triggers from ignored ones. Mode flips while armed separate lockout from a clean return through independent mode. Random traffic with rare mode changes and frequent triggers and done pulses then exercises overlaps, such as a trigger in the same cycle as the end pulse or done arriving late, against a per-cycle reference.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int unsigned MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_INDEP = 2'b00;
  localparam logic [MODE_W-1:0] MODE_RUN   = 2'b01;
  localparam logic [MODE_W-1:0] MODE_TRIG  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SWEEP = 3'd3,
    ST_LOCK  = 3'd4
  } dsm_state_e;

  typedef struct packed {
    dsm_state_e st;
    logic       fire;
  } dsm_step_t;

  // Any code other than the two delaying modes counts as independent.
  function automatic logic mode_is_indep(input logic [MODE_W-1:0] m);
    return !((m == MODE_RUN) || (m == MODE_TRIG));
  endfunction

  // One transition of the controller; independent mode wins over all.
  function automatic dsm_step_t next_step(
    input dsm_state_e        cur,
    input logic [MODE_W-1:0] mode,
    input logic              indep,
    input logic              mode_chg,
    input logic              end_evt,
    input logic              trig_ok,
    input logic              done
  );
    dsm_step_t r;
    r.st   = cur;
    r.fire = 1'b0;
    if (indep) begin
      r.st = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE:  r.st = ST_ARMED;
        ST_ARMED: begin
          if (mode_chg) begin
            r.st = ST_LOCK;
          end else if (end_evt) begin
            if (mode == MODE_RUN) begin
              r.st   = ST_SWEEP;
              r.fire = 1'b1;
            end else begin
              r.st = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mode_chg) begin
            r.st = ST_LOCK;
          end else if (trig_ok) begin
            r.st   = ST_SWEEP;
            r.fire = 1'b1;
          end
        end
        ST_SWEEP: if (done) r.st = ST_ARMED;
        ST_LOCK:  r.st = ST_LOCK;
        default:  r.st = ST_IDLE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/dsm_mode_track.sv
module dsm_mode_track
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              mode_chg,
  output logic              indep
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_INDEP;
    else        mode_q <= mode_sel;
  end

  assign mode_chg = (mode_sel != mode_q);
  assign indep    = mode_is_indep(mode_sel);
endmodule

// File: rtl/dsm_seq.sv
module dsm_seq
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              indep,
  input  logic              mode_chg,
  input  logic              end_evt,
  input  logic              trig_ok,
  input  logic              sweep_done,
  output logic              fire_evt,
  output logic              st_armed,
  output logic              st_wait,
  output logic              in_lock
);
  dsm_state_e state_q;
  dsm_step_t  nxt;

  always_comb begin
    nxt = next_step(state_q, mode_sel, indep, mode_chg, end_evt, trig_ok, sweep_done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt.st;
  end

  assign fire_evt = nxt.fire;
  assign st_armed = (state_q == ST_ARMED);
  assign st_wait  = (state_q == ST_WAIT);
  assign in_lock  = (state_q == ST_LOCK);
endmodule

// File: rtl/dsm_out.sv
module dsm_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_evt,
  input  logic st_armed,
  input  logic st_wait,
  output logic sweep_start,
  output logic armed
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= fire_evt;
  end

  assign sweep_start = start_q;
  assign armed       = st_armed | st_wait;
endmodule

// File: rtl/dsm_sweep_ctrl.sv
module dsm_sweep_ctrl
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              dly_trig,
  input  logic              dly_interval,
  input  logic              sweep_trig,
  input  logic              sweep_done,
  output logic              sweep_start,
  output logic              armed
);
  logic mode_chg;
  logic indep;
  logic trig_ok;
  logic fire_evt;
  logic st_armed;
  logic st_wait;
  logic in_lock;

  // A trigger counts only outside a running delay interval.
  assign trig_ok = sweep_trig & ~dly_interval;

  dsm_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .mode_chg (mode_chg),
    .indep    (indep)
  );

  dsm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .indep      (indep),
    .mode_chg   (mode_chg),
    .end_evt    (dly_trig),
    .trig_ok    (trig_ok),
    .sweep_done (sweep_done),
    .fire_evt   (fire_evt),
    .st_armed   (st_armed),
    .st_wait    (st_wait),
    .in_lock    (in_lock)
  );

  dsm_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_evt    (fire_evt),
    .st_armed    (st_armed),
    .st_wait     (st_wait),
    .sweep_start (sweep_start),
    .armed       (armed)
  );
endmodule

// File: rtl/dsm_sweep_ctrl_chk.sv
module dsm_sweep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       dly_trig,
  input logic       sweep_start,
  input logic       armed,
  input logic       mode_chg,
  input logic       st_armed,
  input logic       in_lock
);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> !sweep_start);

  // R2
  indep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> (!sweep_start && !armed));

  // R7
  disarm_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |-> !armed);

  // R8
  lock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> (!armed && !sweep_start));

  // R3
  run_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mode_chg && mode_sel == 2'b01 && dly_trig) |=> sweep_start);

  // R5
  early_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && mode_sel == 2'b10) |=> !sweep_start);
endmodule

bind dsm_sweep_ctrl dsm_sweep_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .dly_trig    (dly_trig),
  .sweep_start (sweep_start),
  .armed       (armed),
  .mode_chg    (mode_chg),
  .st_armed    (st_armed),
  .in_lock     (in_lock)
);

// File: tb/dsm_sweep_ctrl_test.sv
module dsm_sweep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       dly_trig = 1'b0;
  logic       dly_interval = 1'b0;
  logic       sweep_trig = 1'b0;
  logic       sweep_done = 1'b0;
  logic       sweep_start;
  logic       armed;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  // reference: 0 idle, 1 armed, 2 waiting, 3 sweeping, 4 locked
  int       ref_st   = 0;
  logic     ref_fire = 1'b0;
  logic [1:0] ref_prev = 2'b00;

  always #5 clk = ~clk;

  dsm_sweep_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .dly_trig     (dly_trig),
    .dly_interval (dly_interval),
    .sweep_trig   (sweep_trig),
    .sweep_done   (sweep_done),
    .sweep_start  (sweep_start),
    .armed        (armed)
  );

  function automatic bit is_indep(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Advance the reference by one clock edge using the sampled inputs.
  task automatic ref_update();
    bit changed;
    changed  = (mode_sel != ref_prev);
    ref_fire = 1'b0;
    if (is_indep(mode_sel)) ref_st = 0;
    else begin
      case (ref_st)
        0: ref_st = 1;
        1: if (changed) ref_st = 4;
           else if (dly_trig) begin
             if (mode_sel == 2'b01) begin ref_st = 3; ref_fire = 1'b1; end
             else ref_st = 2;
           end
        2: if (changed) ref_st = 4;
           else if (sweep_trig && !dly_interval) begin ref_st = 3; ref_fire = 1'b1; end
        3: if (sweep_done) ref_st = 1;
        default: ref_st = 4;
      endcase
    end
    ref_prev = mode_sel;
  endtask

  task automatic step(input logic [1:0] m, input logic dt, input logic di,
                      input logic st, input logic sd);
    string tag;
    @(negedge clk);
    mode_sel = m; dly_trig = dt; dly_interval = di; sweep_trig = st; sweep_done = sd;
    @(posedge clk);
    ref_update();
    #1;
    if (ref_st == 4)         tag = "R8";
    else if (is_indep(m))    tag = "R2";
    else if (m == 2'b01)     tag = "R3";
    else                     tag = "R4";
    check(tag, sweep_start, ref_fire);
    check("R10", armed, (ref_st == 1 || ref_st == 2));
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", sweep_start, 1'b0);
    check("R1", armed, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // start-after-delay path
    step(2'b01, 0, 0, 0, 0); check("R10", armed, 1'b1);
    step(2'b01, 1, 0, 0, 0); check("R3", sweep_start, 1'b1); check("R7", armed, 1'b0);
    step(2'b01, 0, 0, 0, 0); check("R6", sweep_start, 1'b0);
    step(2'b01, 1, 0, 1, 0); check("R7", sweep_start, 1'b0); check("R7", armed, 1'b0);
    step(2'b01, 0, 0, 0, 1); check("R7", armed, 1'b1);

    // through independent to triggerable-after-delay
    step(2'b00, 1, 0, 1, 0); check("R2", armed, 1'b0); check("R2", sweep_start, 1'b0);
    step(2'b10, 0, 1, 0, 0); check("R10", armed, 1'b1);
    step(2'b10, 0, 1, 1, 0); check("R5", sweep_start, 1'b0);
    step(2'b10, 0, 0, 1, 0); check("R5", sweep_start, 1'b0);
    step(2'b10, 1, 0, 1, 0); check("R5", sweep_start, 1'b0); check("R4", armed, 1'b1);
    step(2'b10, 0, 1, 1, 0); check("R5", sweep_start, 1'b0);
    step(2'b10, 0, 0, 1, 0); check("R4", sweep_start, 1'b1);
    step(2'b10, 0, 0, 1, 0); check("R6", sweep_start, 1'b0);
    step(2'b10, 0, 0, 0, 1); check("R7", armed, 1'b1);

    // lockout
    step(2'b01, 1, 0, 0, 0); check("R8", armed, 1'b0); check("R8", sweep_start, 1'b0);
    step(2'b01, 1, 0, 1, 1); check("R8", sweep_start, 1'b0); check("R8", armed, 1'b0);
    step(2'b10, 1, 0, 1, 1); check("R9", armed, 1'b0);
    step(2'b10, 0, 0, 0, 0); check("R9", armed, 1'b0);
    step(2'b11, 0, 0, 0, 0); check("R9", armed, 1'b0);
    step(2'b01, 0, 0, 0, 0); check("R9", armed, 1'b1);
    step(2'b01, 1, 0, 0, 0); check("R9", sweep_start, 1'b1);
    step(2'b11, 1, 0, 1, 1); check("R2", sweep_start, 1'b0);

    // constrained random traffic
    void'($urandom(32'h5EED_0D11));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      m = mode_sel;
      if ($urandom_range(39) == 0) m = 2'($urandom_range(3));
      step(m, ($urandom_range(9) == 0), ($urandom_range(2) == 0),
           ($urandom_range(3) == 0), ($urandom_range(7) == 0));
    end

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule